// File: doc/BRIEF.md
# Third-Order Cascaded Fractional Divide Modulator

This block produces the per-cycle divide ratio for a fractional feedback divider. It takes an unsigned eight-bit fractional word and an integer divide value. On every reference cycle, marked by a one-cycle advance strobe, it emits a small signed dither value and the sum of the integer value and that dither. Averaged over many cycles, the sum equals the integer value plus the fraction divided by 256.

The modulator is three first-order accumulator stages in a chain. Each stage adds its input to a held residue. The carry out of the add is its one-bit decision, and the low bits of the add are its new residue. The first stage takes the fraction. Each later stage takes the fresh residue of the stage before it. The three decision streams are then delayed and differenced so that the first stage's error cancels and the remaining error is pushed to high frequencies: the first stream is delayed by two cycles, the second is passed through a first difference and one delay, and the third is passed through a second difference. All state moves only on an advance strobe.

Top module: `mash111_mod`

## Requirements
- R1: While the synchronous active-high reset is applied, the dither output and the divide output both read 0. After reset, every stage residue and every delay tap starts from 0.
- R2: Stage 1 adds the fraction to its residue modulo 256 and reports the carry. Stage 2 does the same with stage 1's new residue, and stage 3 with stage 2's new residue.
- R3: With c1, c2 and c3 the stage carries of strobe k, the dither registered on that strobe is c1[k-2] + c2[k-1] − c2[k-2] + c3[k] − 2·c3[k-1] + c3[k-2]. Carries from before reset count as 0.
- R4: The dither output is four-bit two's complement and always lies between −3 and +4.
- R5: The divide output, one bit wider than the integer input, equals the integer value sampled at a strobe plus the dither registered on that same strobe.
- R6: A cycle without the advance strobe changes neither output nor any internal state. The sequence resumes exactly where it paused.
- R7: With a fraction of 0 after reset, the dither stays 0 and the divide output equals the integer value.
- R8: Over 65536 strobes after reset with a constant fraction F, the dither values sum to 256·F within ±6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance strobe, one per reference cycle |
| frac_i | input | FRAC_W (8) | Fractional part, unsigned |
| int_i | input | INT_W (4) | Integer divide value |
| dither_o | output | 4 | Signed dither of the current cycle |
| div_o | output | INT_W+1 (5) | Instantaneous divide value |

## Verification
The hardest outputs to produce are the extreme dither values +4 and −3. They occur only when the third stage's carry pattern lines up with carries from the other two stages. To reach them, the bench sweeps a wide set of fractions, each over thousands of strobes, and compares every cycle against an arithmetic model. The long-run mean depends on exact residue wrap-around across the whole 256-step period, so a separate run of 65536 strobes checks the summed dither. Pauses in the strobe are placed mid-sequence, so a lost or corrupted residue shows up as a later mismatch.

// File: rtl/mash111_pkg.sv
package mash111_pkg;
  localparam int unsigned STAGES = 3;
  localparam int unsigned DITH_W = 4;
  typedef logic signed [DITH_W-1:0] dither_t;
endpackage

// File: rtl/mash111_stage.sv
module mash111_stage #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic [FRAC_W-1:0] in_i,
  output logic              carry_o,
  output logic [FRAC_W-1:0] resid_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, in_i};
    carry_o = sum[FRAC_W];
    resid_o = sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (adv_i) acc_q <= resid_o;
  end
endmodule

// File: rtl/mash111_comb.sv
module mash111_comb
  import mash111_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                adv_i,
  input  logic [STAGES-1:0]   c_i,
  output dither_t             y_o
);
  logic c1_d1, c1_d2, c2_d1, c2_d2, c3_d1, c3_d2;
  logic signed [DITH_W:0] t;

  always_comb begin
    t = $signed({4'b0000, c1_d2})
      + $signed({4'b0000, c2_d1}) - $signed({4'b0000, c2_d2})
      + $signed({4'b0000, c_i[2]}) - $signed({3'b000, c3_d1, 1'b0})
      + $signed({4'b0000, c3_d2});
    y_o = t[DITH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {c1_d1, c1_d2, c2_d1, c2_d2, c3_d1, c3_d2} <= '0;
    end else if (adv_i) begin
      c1_d1 <= c_i[0];
      c1_d2 <= c1_d1;
      c2_d1 <= c_i[1];
      c2_d2 <= c2_d1;
      c3_d1 <= c_i[2];
      c3_d2 <= c3_d1;
    end
  end
endmodule

// File: rtl/mash111_mod.sv
module mash111_mod
  import mash111_pkg::*;
#(
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned INT_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv_i,
  input  logic [FRAC_W-1:0]  frac_i,
  input  logic [INT_W-1:0]   int_i,
  output logic [DITH_W-1:0]  dither_o,
  output logic [INT_W:0]     div_o
);
  localparam int unsigned DIV_W = INT_W + 1;

  logic [FRAC_W-1:0] chain [STAGES+1];
  logic [STAGES-1:0] carry;
  dither_t           y_next;
  logic [DIV_W-1:0]  div_next;

  assign chain[0] = frac_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    mash111_stage #(.FRAC_W(FRAC_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .adv_i  (adv_i),
      .in_i   (chain[g]),
      .carry_o(carry[g]),
      .resid_o(chain[g+1])
    );
  end

  mash111_comb u_comb (
    .clk  (clk),
    .rst  (rst),
    .adv_i(adv_i),
    .c_i  (carry),
    .y_o  (y_next)
  );

  assign div_next = {1'b0, int_i} + {{(DIV_W-DITH_W){y_next[DITH_W-1]}}, y_next};

  always_ff @(posedge clk) begin
    if (rst) begin
      dither_o <= '0;
      div_o    <= '0;
    end else if (adv_i) begin
      dither_o <= y_next;
      div_o    <= div_next;
    end
  end
endmodule

// File: rtl/mash111_chk.sv
module mash111_chk #(
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned INT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              adv_i,
  input logic [FRAC_W-1:0] frac_i,
  input logic [INT_W-1:0]  int_i,
  input logic [3:0]        dither_o,
  input logic [INT_W:0]    div_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (dither_o == '0 && div_o == '0)); // R1
  AST_DITHER_RANGE: assert property (@(posedge clk) disable iff (rst)
    ($signed(dither_o) >= -4'sd3)); // R4
  AST_DIV_SUM: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> (div_o == ({1'b0, $past(int_i)} + {{(INT_W-3){dither_o[3]}}, dither_o}))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> ($stable(dither_o) && $stable(div_o))); // R6
  AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (rst)
    (adv_i && frac_i == '0 && dither_o == '0 && $past(frac_i) == '0 && $past(frac_i, 2) == '0
     && $past(frac_i, 3) == '0 && !$past(rst) && !$past(rst, 2) && !$past(rst, 3))
    |=> (dither_o == '0)); // R7
endmodule

bind mash111_mod mash111_chk #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
  .clk(clk), .rst(rst), .adv_i(adv_i), .frac_i(frac_i), .int_i(int_i),
  .dither_o(dither_o), .div_o(div_o)
);

// File: tb/mash111_mod_bench.sv
`timescale 1ns/1ps
module mash111_mod_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adv = 1'b0;
  logic [7:0] frac = '0;
  logic [3:0] nint = 4'd8;
  logic [3:0] dither;
  logic [4:0] div;

  int checks = 0;
  int errors = 0;
  int a1, a2, a3, h1a, h1b, h2a, h2b, h3a, h3b, exp_y;
  bit done = 0;

  always #2.5 clk = ~clk;

  mash111_mod u_mash111_mod (
    .clk(clk), .rst(rst), .adv_i(adv), .frac_i(frac), .int_i(nint),
    .dither_o(dither), .div_o(div)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    a1 = 0; a2 = 0; a3 = 0;
    h1a = 0; h1b = 0; h2a = 0; h2b = 0; h3a = 0; h3b = 0; exp_y = 0;
  endtask

  // one strobe of the R2/R3 arithmetic
  task automatic model_step(input int f);
    int s1, s2, s3, c1, c2, c3;
    s1 = a1 + f;  c1 = s1 / 256; a1 = s1 % 256;
    s2 = a2 + a1; c2 = s2 / 256; a2 = s2 % 256;
    s3 = a3 + a2; c3 = s3 / 256; a3 = s3 % 256;
    exp_y = h1b + h2a - h2b + c3 - 2 * h3a + h3b;
    h1b = h1a; h1a = c1;
    h2b = h2a; h2a = c2;
    h3b = h3a; h3a = c3;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; adv = 1'b0;
    @(negedge clk); @(negedge clk);
    check(dither == 4'd0, "R1 dither", int'(dither), 0);
    check(div == 5'd0, "R1 div", int'(div), 0);
    rst = 1'b0;
    model_reset();
  endtask

  // run n strobes, compare every cycle; returns dither sum
  task automatic run(input int f, input int ni, input int n, input bit pauses, output longint sum);
    int bad_y, bad_d, bad_r, first_a, first_e;
    int ys;
    bad_y = 0; bad_d = 0; bad_r = 0; sum = 0; first_a = 0; first_e = 0;
    frac = f[7:0]; nint = ni[3:0];
    for (int k = 0; k < n; k++) begin
      adv = 1'b1;
      @(negedge clk);
      model_step(f);
      ys = int'($signed(dither));
      sum += ys;
      if (ys != exp_y) begin
        if (bad_y == 0) begin first_a = ys; first_e = exp_y; end
        bad_y++;
      end
      if (ys < -3 || ys > 4) bad_r++;
      if (int'(div) != ni + exp_y) bad_d++;
      if (pauses && (k % 97) == 13) begin
        logic [3:0] y_hold; logic [4:0] d_hold;
        y_hold = dither; d_hold = div;
        adv = 1'b0;
        frac = ~f[7:0];
        repeat (3) @(negedge clk);
        check(dither == y_hold && div == d_hold, "R6 hold", int'(div), int'(d_hold));
        frac = f[7:0];
      end
    end
    adv = 1'b0;
    check(bad_y == 0, $sformatf("R2 R3 sequence f=%0d", f), first_a, first_e);
    check(bad_r == 0, "R4 range", bad_r, 0);
    check(bad_d == 0, "R5 divide", bad_d, 0);
  endtask

  initial begin
    longint s;
    int fr [8] = '{0, 1, 37, 64, 128, 171, 200, 255};
    int ni [8] = '{8, 9, 10, 11, 12, 8, 10, 12};
    for (int i = 0; i < 8; i++) begin
      do_reset();
      run(fr[i], ni[i], 4096, (i % 2) == 1, s);
      if (fr[i] == 0) check(s == 0, "R7 zero fraction", int'(s), 0);
    end
    do_reset();
    run(77, 10, 65536, 1'b0, s);
    check(s >= 77 * 256 - 6 && s <= 77 * 256 + 6, "R8 mean", int'(s), 77 * 256);
    do_reset();
    run(3, 12, 65536, 1'b0, s);
    check(s >= 3 * 256 - 6 && s <= 3 * 256 + 6, "R8 mean small", int'(s), 3 * 256);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule